// File: doc/BRIEF.md
# Operand memoization lookup unit

This unit sits next to a pipelined arithmetic unit and skips repeated work. Each incoming operand set is compared, in one cycle, against a small ternary table of frequently seen operand patterns. When a stored pattern matches, the unit raises a clock-gate strobe. That strobe stops the later arithmetic stages for this operation. The unit carries the stored result down a parallel delay line and places it on the output through a multiplexer, at the cycle the arithmetic result would have appeared. When no pattern matches, the arithmetic result passes through unchanged. Either way, results leave in issue order with one fixed latency.

The arithmetic datapath is represented by a fixed-latency stub. The stub adds the 32-bit operands of the key, modulo 2^32. The key holds one, two or three 32-bit operands, set by a parameter. A load port writes a row index, key, care mask, live bit and result. Software uses it to fill the table with profiled patterns before a kernel starts, placing the most frequent pattern at the lowest index.

Top module: `memo_lookup_unit`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `res_valid` and `gate_o` are 0. Reset clears every row's live bit, so a search after reset misses until rows are loaded.
- R2: On a miss, the result is the sum modulo 2^32 of the 32-bit operand fields of the key, and `res_hit` is 0. For the default two operands the fields are bits [31:0] and [63:32].
- R3: A search whose key equals the stored key of a live row in every unmasked bit returns that row's stored result with `res_hit` = 1.
- R4: In the stored mask, bit value 1 means don't care: that key bit takes no part in the compare. Bit value 0 means the bit must be equal.
- R5: When several live rows match, the row with the lowest index supplies the result.
- R6: `gate_o` is high in the cycle that follows the clock edge which captured a hitting search. It is low for misses and for idle cycles.
- R7: A row written with `ld_live` = 0 never matches, even when its key equals the search key.
- R8: One operation can be accepted every cycle. With LAT = 4 (the default), `res_valid` rises LAT-1 clock edges after the edge that captured `op_valid`. Results leave in issue order, and hits and misses have the same latency.
- R9: A load captured at one edge affects searches captured from the next edge on. Writing a row again replaces its key, mask, live bit and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_key | input | KEY_W (64) | Concatenated operands, operand 0 in the low 32 bits |
| ld_en | input | 1 | Write one table row |
| ld_row | input | ROW_W (4) | Row index to write |
| ld_key | input | KEY_W (64) | Stored pattern |
| ld_mask | input | KEY_W (64) | Don't-care mask, 1 = ignore bit |
| ld_live | input | 1 | Live bit written with the row |
| ld_res | input | RES_W (32) | Stored result for the row |
| gate_o | output | 1 | Clock-gate strobe for the later arithmetic stages |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Result came from the table |
| res_data | output | RES_W (32) | Result |

## Verification
The inline assertions check four things every cycle. A gate strobe is always preceded by an accepted operation. A hit flag never appears without a valid result. The matching row that is reported is the lowest-indexed match, and it is a live row. The count of operations in flight never exceeds the pipeline depth. Only the bench scenarios can show the values themselves and the timing of each result. These cover stored versus computed data, masked-bit matching, overlapping rows, dead rows, 32-bit wrap of the sum, exact latency under back-to-back issue, and row rewrites taking effect on the next search.

// File: rtl/memo_pkg.sv
package memo_pkg;
   localparam int unsigned OPND_W   = 32;
   localparam int unsigned DEF_OPS  = 2;
   localparam int unsigned DEF_ROWS = 16;
   localparam int unsigned DEF_LAT  = 4;
endpackage

// File: rtl/memo_pattern_table.sv
module memo_pattern_table #(
   parameter int KEY_W = 64,
   parameter int ROWS  = 16,
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [ROW_W-1:0] ld_row,
   input  logic [KEY_W-1:0] ld_key,
   input  logic [KEY_W-1:0] ld_mask,
   input  logic             ld_live,
   input  logic [KEY_W-1:0] srch_key,
   output logic             hit_o,
   output logic [ROW_W-1:0] row_o
);
   logic [KEY_W-1:0] key_q  [ROWS];
   logic [KEY_W-1:0] mask_q [ROWS];
   logic [ROWS-1:0]  live_q;
   logic [ROWS-1:0]  match_vec;
   logic [ROWS-1:0]  below_m;

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q <= '0;
      end else if (ld_en) begin
         live_q[ld_row] <= ld_live;
      end
   end

   always_ff @(posedge clk) begin
      if (ld_en) begin
         key_q[ld_row]  <= ld_key;
         mask_q[ld_row] <= ld_mask;
      end
   end

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_cmp
         assign match_vec[r] = live_q[r] &&
                               (((srch_key ^ key_q[r]) & ~mask_q[r]) == '0);
      end
   endgenerate

   always_comb begin
      hit_o = 1'b0;
      row_o = '0;
      for (int i = ROWS - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            hit_o = 1'b1;
            row_o = ROW_W'(i);
         end
      end
   end

   always_comb begin
      below_m = (ROWS'(1) << row_o) - ROWS'(1);
   end

   // R5
   prio_chk: assert property (@(posedge clk) disable iff (rst)
      hit_o |-> (match_vec[row_o] && ((match_vec & below_m) == '0)));

   // R7
   live_row_chk: assert property (@(posedge clk) disable iff (rst)
      hit_o |-> live_q[row_o]);
endmodule

// File: rtl/memo_result_table.sv
module memo_result_table #(
   parameter int RES_W = 32,
   parameter int ROWS  = 16,
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             ld_en,
   input  logic [ROW_W-1:0] ld_row,
   input  logic [RES_W-1:0] ld_res,
   input  logic [ROW_W-1:0] rd_row,
   output logic [RES_W-1:0] rd_data
);
   logic [RES_W-1:0] res_q [ROWS];

   always_ff @(posedge clk) begin
      if (ld_en) begin
         res_q[ld_row] <= ld_res;
      end
   end

   assign rd_data = res_q[rd_row];
endmodule

// File: rtl/memo_arith_stub.sv
module memo_arith_stub #(
   parameter int NUM_OPS = 2,
   parameter int OPW     = 32,
   parameter int LAT     = 4,
   localparam int KW     = NUM_OPS * OPW
) (
   input  logic           clk,
   input  logic [LAT-1:0] stage_en,
   input  logic [KW-1:0]  key_i,
   output logic [OPW-1:0] res_o
);
   logic [OPW-1:0] fold;
   logic [OPW-1:0] stg_q [LAT];

   generate
      if (NUM_OPS == 1) begin : g_one
         assign fold = key_i;
      end else begin : g_multi
         always_comb begin
            fold = '0;
            for (int k = 0; k < NUM_OPS; k++) begin
               fold = fold + key_i[k*OPW +: OPW];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (stage_en[0]) begin
         stg_q[0] <= fold;
      end
      for (int s = 1; s < LAT; s++) begin
         if (stage_en[s]) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign res_o = stg_q[LAT-1];
endmodule

// File: rtl/memo_lookup_unit.sv
module memo_lookup_unit
   import memo_pkg::*;
#(
   parameter int NUM_OPS = DEF_OPS,
   parameter int ROWS    = DEF_ROWS,
   parameter int LAT     = DEF_LAT,
   localparam int KEY_W  = NUM_OPS * OPND_W,
   localparam int RES_W  = OPND_W,
   localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             op_valid,
   input  logic [KEY_W-1:0] op_key,
   input  logic             ld_en,
   input  logic [ROW_W-1:0] ld_row,
   input  logic [KEY_W-1:0] ld_key,
   input  logic [KEY_W-1:0] ld_mask,
   input  logic             ld_live,
   input  logic [RES_W-1:0] ld_res,
   output logic             gate_o,
   output logic             res_valid,
   output logic             res_hit,
   output logic [RES_W-1:0] res_data
);
   localparam int CNT_W = $clog2(LAT + 2) + 1;

   generate
      if (LAT < 2) begin : g_bad_lat
         $error("memo_lookup_unit: LAT must be at least 2");
      end
      if (NUM_OPS < 1 || NUM_OPS > 3) begin : g_bad_ops
         $error("memo_lookup_unit: NUM_OPS must be 1, 2 or 3");
      end
      if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("memo_lookup_unit: ROWS must be a power of two, at least 2");
      end
   endgenerate

   logic             srch_hit;
   logic [ROW_W-1:0] srch_row;
   logic [RES_W-1:0] tbl_res;
   logic [RES_W-1:0] arith_res;
   logic [LAT-1:0]   stage_en;
   logic [LAT-1:0]   vld_q;
   logic [LAT-1:0]   hit_q;
   logic [RES_W-1:0] memo_q [LAT];
   logic [CNT_W-1:0] fly_q;

   memo_pattern_table #(.KEY_W(KEY_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_pat (
      .clk      (clk),
      .rst      (rst),
      .ld_en    (ld_en),
      .ld_row   (ld_row),
      .ld_key   (ld_key),
      .ld_mask  (ld_mask),
      .ld_live  (ld_live),
      .srch_key (op_key),
      .hit_o    (srch_hit),
      .row_o    (srch_row)
   );

   memo_result_table #(.RES_W(RES_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_res (
      .clk     (clk),
      .ld_en   (ld_en),
      .ld_row  (ld_row),
      .ld_res  (ld_res),
      .rd_row  (srch_row),
      .rd_data (tbl_res)
   );

   assign stage_en[0] = op_valid;
   generate
      for (genvar s = 1; s < LAT; s++) begin : g_gate
         assign stage_en[s] = vld_q[s-1] & ~hit_q[s-1];
      end
   endgenerate

   memo_arith_stub #(.NUM_OPS(NUM_OPS), .OPW(OPND_W), .LAT(LAT)) u_alu (
      .clk      (clk),
      .stage_en (stage_en),
      .key_i    (op_key),
      .res_o    (arith_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
         hit_q <= '0;
      end else begin
         vld_q <= {vld_q[LAT-2:0], op_valid};
         hit_q <= {hit_q[LAT-2:0], op_valid & srch_hit};
      end
   end

   always_ff @(posedge clk) begin
      if (op_valid && srch_hit) begin
         memo_q[0] <= tbl_res;
      end
      for (int s = 1; s < LAT; s++) begin
         if (hit_q[s-1]) begin
            memo_q[s] <= memo_q[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fly_q <= '0;
      end else begin
         fly_q <= fly_q + CNT_W'(op_valid) - CNT_W'(res_valid);
      end
   end

   assign gate_o    = hit_q[0];
   assign res_valid = vld_q[LAT-1];
   assign res_hit   = hit_q[LAT-1];
   assign res_data  = res_hit ? memo_q[LAT-1] : arith_res;

   // R6
   gate_src_chk: assert property (@(posedge clk) disable iff (rst)
      gate_o |-> $past(op_valid));

   // R3
   hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
      res_hit |-> res_valid);

   // R8
   inflight_chk: assert property (@(posedge clk) disable iff (rst)
      fly_q <= CNT_W'(LAT));

   // R8
   out_src_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (fly_q != '0));
endmodule

// File: tb/memo_lookup_unit_test.sv
`timescale 1ns/100ps
module memo_lookup_unit_test;
   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [63:0] op_key = '0;
   logic        ld_en = 1'b0;
   logic [3:0]  ld_row = '0;
   logic [63:0] ld_key = '0;
   logic [63:0] ld_mask = '0;
   logic        ld_live = 1'b0;
   logic [31:0] ld_res = '0;
   logic        gate_o;
   logic        res_valid;
   logic        res_hit;
   logic [31:0] res_data;

   memo_lookup_unit uut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_key(op_key),
      .ld_en(ld_en), .ld_row(ld_row), .ld_key(ld_key), .ld_mask(ld_mask),
      .ld_live(ld_live), .ld_res(ld_res), .gate_o(gate_o),
      .res_valid(res_valid), .res_hit(res_hit), .res_data(res_data)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit exp_gate = 1'b0;

   logic [63:0] m_key  [16];
   logic [63:0] m_mask [16];
   bit          m_live [16];
   logic [31:0] m_res  [16];

   logic [31:0] q_data [$];
   bit          q_hit  [$];
   int          q_iss  [$];
   string       q_tag  [$];

   localparam logic [63:0] VEC_KEY [10] = '{
      {32'h5, 32'h3},            // R3 row0 exact
      {32'h10, 32'h20},          // R5 rows 1 and 2 both match, row1 wins
      {32'h10, 32'h2F},          // R4 low byte masked in row1
      {32'h10, 32'h120},         // R4 bit 8 not masked: miss
      {32'h7, 32'h7},            // R7 row3 not live: miss
      {32'hFFFF_FFFF, 32'h2},    // R2 wrap
      {32'h5, 32'h3},            // R3 again
      {32'h11, 32'h20},          // R4 bit 32 not masked: miss
      {32'h0, 32'h0},            // R2 zero
      {32'h10, 32'hFF}           // R4 masked byte all ones
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic void predict(input logic [63:0] k, output bit h, output logic [31:0] r);
      h = 1'b0;
      r = k[31:0] + k[63:32];
      for (int i = 15; i >= 0; i--) begin
         if (m_live[i] && (((k ^ m_key[i]) & ~m_mask[i]) == 64'h0)) begin
            h = 1'b1;
            r = m_res[i];
         end
      end
   endfunction

   task automatic idle();
      @(negedge clk);
      op_valid = 1'b0;
      ld_en    = 1'b0;
      exp_gate = 1'b0;
   endtask

   task automatic load_row(input int row, input logic [63:0] k, input logic [63:0] m,
                           input bit live, input logic [31:0] r);
      @(negedge clk);
      op_valid = 1'b0;
      ld_en    = 1'b1;
      ld_row   = 4'(row);
      ld_key   = k;
      ld_mask  = m;
      ld_live  = live;
      ld_res   = r;
      exp_gate = 1'b0;
      m_key[row]  = k;
      m_mask[row] = m;
      m_live[row] = live;
      m_res[row]  = r;
   endtask

   task automatic search(input logic [63:0] k, input string tag);
      bit h;
      logic [31:0] r;
      @(negedge clk);
      ld_en    = 1'b0;
      op_valid = 1'b1;
      op_key   = k;
      predict(k, h, r);
      q_data.push_back(r);
      q_hit.push_back(h);
      q_iss.push_back(cyc);
      q_tag.push_back(tag);
      exp_gate = h;
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // Output monitor, sampled just after each active edge
   always @(posedge clk) begin
      #1;
      if (rst) begin
         check("R1 res_valid in reset", 64'(res_valid), 64'h0);
         check("R1 gate_o in reset", 64'(gate_o), 64'h0);
      end else begin
         check("R6 gate_o", 64'(gate_o), 64'(exp_gate));
         if (res_valid) begin
            if (q_data.size() == 0) begin
               check("R8 unexpected result", 64'h1, 64'h0);
            end else begin
               string t;
               int iss;
               t = q_tag.pop_front();
               iss = q_iss.pop_front();
               check({t, " data"}, 64'(res_data), 64'(q_data.pop_front()));
               check({t, " hit"}, 64'(res_hit), 64'(q_hit.pop_front()));
               check("R8 latency", 64'(cyc - iss), 64'(LAT));
            end
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_live[i] = 1'b0;
         m_key[i]  = '0;
         m_mask[i] = '0;
         m_res[i]  = '0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: first cycle out of reset, outputs still low
      @(posedge clk);
      #1;
      check("R1 res_valid after reset", 64'(res_valid), 64'h0);
      check("R1 gate_o after reset", 64'(gate_o), 64'h0);
      // R1: empty table misses
      search({32'h5, 32'h3}, "R1");
      idle();
      repeat (LAT + 1) idle();

      load_row(0, {32'h5, 32'h3}, 64'h0, 1'b1, 32'd100);
      load_row(1, {32'h10, 32'h20}, 64'hFF, 1'b1, 32'd200);
      load_row(2, {32'h10, 32'h20}, 64'h0, 1'b1, 32'd300);
      load_row(3, {32'h7, 32'h7}, 64'h0, 1'b0, 32'd400); // R7
      idle();

      // R8: back-to-back vectors from the table
      for (int v = 0; v < 10; v++) begin
         bit h;
         logic [31:0] r;
         predict(VEC_KEY[v], h, r);
         search(VEC_KEY[v], h ? "R3" : "R2");
      end
      repeat (LAT + 1) idle();

      // R9: load then search on the following cycle, then rewrite
      load_row(5, {32'hAA, 32'hBB}, 64'h0, 1'b1, 32'd500);
      search({32'hAA, 32'hBB}, "R9 new row");
      load_row(5, {32'hAA, 32'hBB}, 64'h0, 1'b1, 32'd555);
      search({32'hAA, 32'hBB}, "R9 rewrite");
      load_row(5, {32'hAA, 32'hBB}, 64'h0, 1'b0, 32'd555);
      search({32'hAA, 32'hBB}, "R7 row killed");
      // R6: hit, miss, hit gating pattern with gaps
      search({32'h5, 32'h3}, "R6 hit");
      idle();
      search({32'h1, 32'h1}, "R6 miss");
      search({32'h10, 32'h20}, "R5 overlap");
      repeat (2 * LAT) idle();

      check("R8 all results drained", 64'(q_data.size()), 64'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule